// File: doc/BRIEF.md
# Criticality-Aware Instruction Dispatcher

This block sits between an issue stage and a pool of functional units. It steers every incoming instruction by the timing-criticality class of its opcode, and it never balances load across the units. Each opcode has one class bit in a software-writable table. Instructions marked timing-critical may run only on a small reserved group of units, the low-numbered ones. All other instructions run only on the remaining units. Within a group, the lowest-numbered unit that can take an instruction receives it. When no unit in the group can take it, the input sees backpressure.

Critical instructions are a small minority of the stream, so the reserved units sit idle most of the time. The dispatcher uses this idle time to reduce wear on them. After a programmable run of cycles with no critical instruction offered, a reserved unit is parked. Parking takes one of two forms, chosen by a mode input: the unit's inputs are clamped to a fixed low-stress vector, or the unit is power-gated. When a critical instruction arrives and no awake reserved unit can take it, every parked reserved unit is released. A released unit becomes eligible only after a programmable wake-up delay, and the instruction is held off until then.

Operands and the opcode are broadcast to all units. Each unit has its own valid and ready signals. Two counters record how many critical and how many non-critical instructions have been handed over.

Top module: `critsteer_dispatch`

## Requirements
- R1: The class table holds one bit per opcode (1 = timing-critical). Every entry resets to 0. A write with `cfg_we` high sets entry `cfg_opc` to `cfg_crit`, and the new value steers instructions from the next cycle onward.
- R2: A critical instruction is issued only to a unit with index below NUM_CRIT. A non-critical instruction is issued only to a unit with index NUM_CRIT or above. If the right group cannot take an instruction, it waits, even when units of the other group are ready.
- R3: Among the eligible units of the right group, the lowest-indexed one receives the instruction. At most one `fu_valid` bit is high in any cycle. Units that are idle or lightly used get no preference.
- R4: `in_ready` is high exactly when the class of `in_opcode` has an eligible unit. A unit is eligible when its `fu_ready` is high and, for a reserved unit, when it is awake. `fu_valid[i]` is high only when `in_valid` and `fu_ready[i]` are both high.
- R5: After reset, every reserved unit is parked.
- R6: An awake reserved unit parks once `cfg_idle_limit` consecutive cycles have passed with no critical instruction offered at the input. A limit of 0 behaves as a limit of 1. The park output rises in the cycle after the last idle cycle.
- R7: A parked unit drives `fu_clamp` when `cfg_park_mode` is 0 and `fu_gate` when it is 1, never both. An unparked unit drives neither.
- R8: Consider a critical instruction offered in cycle t while no awake reserved unit is ready. Parked reserved units drop their park outputs in cycle t+1. With W = `cfg_wake_cycles`, they become eligible in cycle t+1+W. Until then `in_ready` stays low for that instruction.
- R9: `crit_issued` and `norm_issued` both reset to 0. Each completed handshake increments the counter of its class by one, visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Class table write strobe |
| cfg_opc | input | OPC_W | Opcode whose class is written |
| cfg_crit | input | 1 | Class written (1 = critical) |
| cfg_park_mode | input | 1 | 0 = clamp inputs, 1 = power-gate |
| cfg_idle_limit | input | IDLE_W | Idle cycles before a reserved unit parks |
| cfg_wake_cycles | input | WAKE_W | Wake-up delay in cycles |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_opcode | input | OPC_W | Opcode |
| in_opa | input | DATA_W | First operand |
| in_opb | input | DATA_W | Second operand |
| fu_valid | output | NUM_FU | Per-unit issue strobe |
| fu_ready | input | NUM_FU | Per-unit ability to accept |
| fu_opcode | output | OPC_W | Broadcast opcode |
| fu_opa | output | DATA_W | Broadcast first operand |
| fu_opb | output | DATA_W | Broadcast second operand |
| fu_clamp | output | NUM_CRIT | Apply fixed input vector to reserved unit |
| fu_gate | output | NUM_CRIT | Power-gate reserved unit |
| crit_issued | output | CNT_W | Critical instructions handed over |
| norm_issued | output | CNT_W | Non-critical instructions handed over |

## Verification
The assertions assume that `cfg_idle_limit` and `cfg_wake_cycles` do not change while a reserved unit is counting idle cycles or waking. They also assume that every input is a defined value once reset is released. The stimulus changes these settings only at points in a directed sequence where their effect is accounted for. During the random phase the settings stay fixed, and a critical opcode is forced in well before the idle limit runs out, so the reserved unit remains awake and routing can be predicted from the class table and the ready pattern alone. Class table writes happen only in cycles with no instruction offered.

// File: rtl/critsteer_pkg.sv
package critsteer_pkg;
    typedef enum logic [1:0] {
        PK_AWAKE  = 2'd0,
        PK_PARKED = 2'd1,
        PK_WAKING = 2'd2
    } park_state_e;
endpackage

// File: rtl/critsteer_class_table.sv
module critsteer_class_table #(
    parameter int OPC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OPC_W-1:0] wr_opc,
    input  logic             wr_crit,
    input  logic [OPC_W-1:0] rd_opc,
    output logic             rd_crit
);
    localparam int DEPTH = 1 << OPC_W;

    typedef struct packed {
        logic [DEPTH-1:0] cls;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.cls[wr_opc] = wr_crit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_crit = tbl_q.cls[rd_opc];

    // R1: a written class is what the table holds afterwards
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q.cls[$past(wr_opc)] == $past(wr_crit)));
endmodule

// File: rtl/critsteer_lowest_pick.sv
module critsteer_lowest_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/critsteer_park_ctrl.sv
module critsteer_park_ctrl
    import critsteer_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crit_seen,
    input  logic              wake_req,
    input  logic              issue,
    input  logic              park_mode,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [WAKE_W-1:0] wake_cycles,
    output logic              awake,
    output logic              clamp,
    output logic              gate
);
    typedef struct packed {
        park_state_e       st;
        logic [IDLE_W-1:0] idle;
        logic [WAKE_W-1:0] wake;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [IDLE_W:0] idle_inc;

    always_comb begin
        pk_d     = pk_q;
        idle_inc = {1'b0, pk_q.idle} + 1'b1;
        case (pk_q.st)
            PK_AWAKE: begin
                if (crit_seen) begin
                    pk_d.idle = '0;
                end else if (idle_inc >= {1'b0, idle_limit}) begin
                    pk_d.st   = PK_PARKED;
                    pk_d.idle = '0;
                end else begin
                    pk_d.idle = idle_inc[IDLE_W-1:0];
                end
            end
            PK_PARKED: begin
                if (wake_req) begin
                    if (wake_cycles == '0) begin
                        pk_d.st   = PK_AWAKE;
                        pk_d.idle = '0;
                    end else begin
                        pk_d.st   = PK_WAKING;
                        pk_d.wake = wake_cycles;
                    end
                end
            end
            PK_WAKING: begin
                if (pk_q.wake <= 1) begin
                    pk_d.st   = PK_AWAKE;
                    pk_d.idle = '0;
                    pk_d.wake = '0;
                end else begin
                    pk_d.wake = pk_q.wake - 1'b1;
                end
            end
            default: pk_d.st = PK_PARKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '{st: PK_PARKED, idle: '0, wake: '0};
        end else begin
            pk_q <= pk_d;
        end
    end

    assign awake = (pk_q.st == PK_AWAKE);
    assign clamp = (pk_q.st == PK_PARKED) && !park_mode;
    assign gate  = (pk_q.st == PK_PARKED) && park_mode;

    // R7: the two parking forms never coexist
    p_one_park_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp && gate));
    // R8: a unit receives work only while awake
    p_issue_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> awake);
    // R8: a wake request lifts the park outputs next cycle
    p_wake_lifts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.st == PK_PARKED && wake_req) |=> !(clamp || gate));
    // R6: parking starts only after a cycle with no critical work
    p_park_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(awake) && !awake && !(pk_q.st == PK_WAKING)) |-> $past(!crit_seen));
endmodule

// File: rtl/critsteer_dispatch.sv
module critsteer_dispatch #(
    parameter int NUM_FU   = 4,
    parameter int NUM_CRIT = 1,
    parameter int OPC_W    = 4,
    parameter int DATA_W   = 16,
    parameter int IDLE_W   = 8,
    parameter int WAKE_W   = 4,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [OPC_W-1:0]    cfg_opc,
    input  logic                cfg_crit,
    input  logic                cfg_park_mode,
    input  logic [IDLE_W-1:0]   cfg_idle_limit,
    input  logic [WAKE_W-1:0]   cfg_wake_cycles,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [OPC_W-1:0]    in_opcode,
    input  logic [DATA_W-1:0]   in_opa,
    input  logic [DATA_W-1:0]   in_opb,
    output logic [NUM_FU-1:0]   fu_valid,
    input  logic [NUM_FU-1:0]   fu_ready,
    output logic [OPC_W-1:0]    fu_opcode,
    output logic [DATA_W-1:0]   fu_opa,
    output logic [DATA_W-1:0]   fu_opb,
    output logic [NUM_CRIT-1:0] fu_clamp,
    output logic [NUM_CRIT-1:0] fu_gate,
    output logic [CNT_W-1:0]    crit_issued,
    output logic [CNT_W-1:0]    norm_issued
);
    localparam int NUM_NORM = NUM_FU - NUM_CRIT;

    typedef struct packed {
        logic [CNT_W-1:0] crit;
        logic [CNT_W-1:0] norm;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    logic                is_crit;
    logic [NUM_CRIT-1:0] crit_awake;
    logic [NUM_CRIT-1:0] crit_elig;
    logic [NUM_CRIT-1:0] crit_gnt;
    logic [NUM_NORM-1:0] norm_elig;
    logic [NUM_NORM-1:0] norm_gnt;
    logic                crit_any;
    logic                norm_any;
    logic                crit_seen;
    logic                wake_req;
    logic                fire;

    critsteer_class_table #(.OPC_W(OPC_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_opc  (cfg_opc),
        .wr_crit (cfg_crit),
        .rd_opc  (in_opcode),
        .rd_crit (is_crit)
    );

    assign crit_elig = fu_ready[NUM_CRIT-1:0] & crit_awake;
    assign norm_elig = fu_ready[NUM_FU-1:NUM_CRIT];

    critsteer_lowest_pick #(.N(NUM_CRIT)) u_pick_crit (
        .req (crit_elig),
        .gnt (crit_gnt),
        .any (crit_any)
    );

    critsteer_lowest_pick #(.N(NUM_NORM)) u_pick_norm (
        .req (norm_elig),
        .gnt (norm_gnt),
        .any (norm_any)
    );

    always_comb begin
        in_ready = is_crit ? crit_any : norm_any;
        fu_valid = '0;
        if (in_valid) begin
            fu_valid = is_crit ? {{NUM_NORM{1'b0}}, crit_gnt}
                               : {norm_gnt, {NUM_CRIT{1'b0}}};
        end
    end

    assign crit_seen = in_valid && is_crit;
    assign wake_req  = crit_seen && !crit_any;
    assign fire      = in_valid && in_ready;

    generate
        for (genvar c = 0; c < NUM_CRIT; c++) begin : g_park
            critsteer_park_ctrl #(.IDLE_W(IDLE_W), .WAKE_W(WAKE_W)) u_park (
                .clk         (clk),
                .rst_n       (rst_n),
                .crit_seen   (crit_seen),
                .wake_req    (wake_req),
                .issue       (fu_valid[c]),
                .park_mode   (cfg_park_mode),
                .idle_limit  (cfg_idle_limit),
                .wake_cycles (cfg_wake_cycles),
                .awake       (crit_awake[c]),
                .clamp       (fu_clamp[c]),
                .gate        (fu_gate[c])
            );
        end
    endgenerate

    assign fu_opcode = in_opcode;
    assign fu_opa    = in_opa;
    assign fu_opb    = in_opb;

    always_comb begin
        cnt_d = cnt_q;
        if (fire && is_crit) begin
            cnt_d.crit = cnt_q.crit + 1'b1;
        end
        if (fire && !is_crit) begin
            cnt_d.norm = cnt_q.norm + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign crit_issued = cnt_q.crit;
    assign norm_issued = cnt_q.norm;

    // R2: each class reaches only its own group of units
    p_crit_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|fu_valid[NUM_CRIT-1:0]) |-> is_crit);
    p_norm_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|fu_valid[NUM_FU-1:NUM_CRIT]) |-> !is_crit);
    // R3: single issue, lowest eligible index
    p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_valid));
    p_lowest_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_gnt != '0) |-> (((norm_gnt - 1'b1) & norm_elig) == '0));
    // R9: counters step once per handshake of their class
    p_crit_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_crit) |=> (crit_issued == $past(crit_issued) + 1'b1));
    p_norm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && !is_crit) |=> $stable(norm_issued));

    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
            // R4: no issue to a unit that is not ready
            p_ready_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                fu_valid[u] |-> (fu_ready[u] && in_valid));
        end
    endgenerate
endmodule

// File: tb/critsteer_dispatch_bench.sv
module critsteer_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_opc = '0;
    logic        cfg_crit = 1'b0;
    logic        cfg_park_mode = 1'b0;
    logic [7:0]  cfg_idle_limit = 8'd4;
    logic [3:0]  cfg_wake_cycles = 4'd3;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_opcode = '0;
    logic [15:0] in_opa = '0;
    logic [15:0] in_opb = '0;
    logic [3:0]  fu_valid;
    logic [3:0]  fu_ready = '0;
    logic [3:0]  fu_opcode;
    logic [15:0] fu_opa;
    logic [15:0] fu_opb;
    logic [0:0]  fu_clamp;
    logic [0:0]  fu_gate;
    logic [15:0] crit_issued;
    logic [15:0] norm_issued;

    critsteer_dispatch u_critsteer_dispatch (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opc(cfg_opc),
        .cfg_crit(cfg_crit), .cfg_park_mode(cfg_park_mode),
        .cfg_idle_limit(cfg_idle_limit), .cfg_wake_cycles(cfg_wake_cycles),
        .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
        .in_opa(in_opa), .in_opb(in_opb), .fu_valid(fu_valid),
        .fu_ready(fu_ready), .fu_opcode(fu_opcode), .fu_opa(fu_opa),
        .fu_opb(fu_opb), .fu_clamp(fu_clamp), .fu_gate(fu_gate),
        .crit_issued(crit_issued), .norm_issued(norm_issued)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int exp_crit_cnt = 0;
    int exp_norm_cnt = 0;
    bit tbl_m [16];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected routing with the reserved unit awake (unit 0 reserved)
    function automatic logic [3:0] exp_route(bit v, bit crit, logic [3:0] rdy);
        if (!v) return 4'b0000;
        if (crit) return rdy[0] ? 4'b0001 : 4'b0000;
        for (int i = 1; i < 4; i++) begin
            if (rdy[i]) return 4'(1 << i);
        end
        return 4'b0000;
    endfunction

    function automatic bit exp_rdy(bit crit, logic [3:0] rdy);
        return crit ? rdy[0] : (|rdy[3:1]);
    endfunction

    // one cycle: drive after the edge, leave the sample point 1 ns later
    task automatic drive(bit v, logic [3:0] opc, logic [3:0] rdy);
        @(posedge clk);
        #1;
        cfg_we    = 1'b0;
        in_valid  = v;
        in_opcode = opc;
        in_opa    = 16'($urandom);
        in_opb    = 16'($urandom);
        fu_ready  = rdy;
        #1;
        if (in_valid && in_ready) begin
            if (tbl_m[in_opcode]) exp_crit_cnt++;
            else exp_norm_cnt++;
        end
    endtask

    task automatic wr_tbl(logic [3:0] opc, bit c);
        @(posedge clk);
        #1;
        cfg_we   = 1'b1;
        cfg_opc  = opc;
        cfg_crit = c;
        in_valid = 1'b0;
        tbl_m[opc] = c;
        #1;
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int since_crit;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state: R5, R9, R1 default class
        drive(0, 4'd5, 4'b1111);
        chk("R5 clamp after reset", 32'(fu_clamp), 32'd1);
        chk("R5 gate after reset", 32'(fu_gate), 32'd0);
        chk("R9 crit count reset", 32'(crit_issued), 32'd0);
        chk("R9 norm count reset", 32'(norm_issued), 32'd0);
        drive(1, 4'd5, 4'b1111);
        chk("R1 default class routes to unit 1", 32'(fu_valid), 32'b0010);
        chk("R4 ready for normal op", 32'(in_ready), 32'd1);
        chk("R2 broadcast operand", 32'(fu_opa), 32'(in_opa));

        // R3 lowest index, R4 backpressure
        drive(1, 4'd6, 4'b1101);
        chk("R3 lowest eligible", 32'(fu_valid), 32'b0100);
        drive(1, 4'd7, 4'b0001);
        chk("R4 no normal unit ready", 32'(in_ready), 32'd0);
        chk("R2 normal op not to reserved", 32'(fu_valid), 32'd0);
        drive(1, 4'd2, 4'b1000);
        chk("R3 only highest ready", 32'(fu_valid), 32'b1000);

        // R7 power-gate form
        cfg_park_mode = 1'b1;
        drive(0, 4'd0, 4'b1111);
        chk("R7 gate in mode 1", 32'(fu_gate), 32'd1);
        chk("R7 no clamp in mode 1", 32'(fu_clamp), 32'd0);
        cfg_park_mode = 1'b0;

        // R1 write, R8 wake with W=3
        wr_tbl(4'd3, 1'b1);
        drive(1, 4'd3, 4'b1111);
        chk("R8 stall while parked", 32'(in_ready), 32'd0);
        chk("R2 critical not to other units", 32'(fu_valid), 32'd0);
        for (int k = 1; k <= 3; k++) begin
            drive(1, 4'd3, 4'b1111);
            chk("R8 park lifted during wake", 32'(fu_clamp), 32'd0);
            chk("R8 stall during wake", 32'(in_ready), 32'd0);
        end
        drive(1, 4'd3, 4'b1111);
        chk("R8 accepted after wake", 32'(fu_valid), 32'b0001);

        // R2 critical waits on busy reserved unit
        drive(1, 4'd3, 4'b1110);
        chk("R2 critical waits", 32'(in_ready), 32'd0);
        chk("R2 critical not to other units", 32'(fu_valid), 32'd0);

        // R6 park after 4 idle cycles
        for (int k = 0; k < 4; k++) begin
            drive(1, 4'd5, 4'b1111);
            chk("R6 awake before limit", 32'(fu_clamp), 32'd0);
            chk("R3 normal flow", 32'(fu_valid), 32'b0010);
        end
        drive(0, 4'd5, 4'b1111);
        chk("R6 parked after limit", 32'(fu_clamp), 32'd1);

        // R8 wake with W=0
        cfg_wake_cycles = 4'd0;
        drive(1, 4'd3, 4'b1111);
        chk("R8 W0 stall first cycle", 32'(in_ready), 32'd0);
        drive(1, 4'd3, 4'b1111);
        chk("R8 W0 accepted next cycle", 32'(fu_valid), 32'b0001);

        // R1 clear entry
        wr_tbl(4'd3, 1'b0);
        drive(1, 4'd3, 4'b1111);
        chk("R1 cleared entry routes normal", 32'(fu_valid), 32'b0010);

        // random phase
        cfg_idle_limit  = 8'd255;
        cfg_wake_cycles = 4'd2;
        wr_tbl(4'd3, 1'b1);
        wr_tbl(4'd9, 1'b1);
        wr_tbl(4'd12, 1'b1);
        for (int k = 0; k < 10; k++) begin
            drive(1, 4'd3, 4'b0001);
            if (in_ready) break;
        end
        since_crit = 0;
        for (int n = 0; n < 3000; n++) begin
            bit v;
            logic [3:0] opc;
            logic [3:0] rdy;
            v   = ($urandom % 4) != 0;
            opc = 4'($urandom);
            rdy = 4'($urandom);
            if (since_crit >= 100) begin
                v   = 1'b1;
                opc = 4'd9;
            end
            if (v && tbl_m[opc]) since_crit = 0;
            else since_crit++;
            drive(v, opc, rdy);
            chk("R2 R3 random routing", 32'(fu_valid), 32'(exp_route(v, tbl_m[opc], rdy)));
            chk("R4 random ready", 32'(in_ready), 32'(exp_rdy(tbl_m[opc], rdy)));
        end

        drive(0, 4'd0, 4'b0000);
        chk("R9 crit count", 32'(crit_issued), 32'(exp_crit_cnt));
        chk("R9 norm count", 32'(norm_issued), 32'(exp_norm_cnt));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule